// File: doc/BRIEF.md
# Dual-Plane Pixel Frame Buffer Bridge

This bridge connects a 16-bit synchronous CPU request/acknowledge port to a 16-bit word memory that holds a frame buffer. Every memory word holds exactly one 8-bit pixel. The pixel is split across the word's two byte lanes. The upper five bits form the static part and go in the upper byte. The lower three bits form the dynamic part and go in the lower byte. The CPU sees two separate byte-per-pixel planes. One address bit chooses between them, so software can change the static or the dynamic part of a pixel without a read-modify-write.

A CPU word carries two pixels: the even pixel in the low byte and the odd pixel in the high byte. The bridge repacks these into one or two memory beats. It routes and masks each plane's bits into their lane and sets the byte enables so that only that lane is written. On reads it always fetches two words and zeroes the bits that belong to the other plane. Only one CPU transaction is in flight at a time. The acknowledge waits until the last memory beat has completed.

Top module: `fb_plane_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `cpu_ack` and `mem_req` are low.
- R2: CPU address bit `PLANE_BIT` selects the plane (0 static, 1 dynamic). The memory word address is the pixel index formed from the CPU address bits below it. CPU address bit 0 is ignored; the byte enables pick the pixel (`cpu_be[0]` selects the even pixel at the index with bit 0 cleared, `cpu_be[1]` selects the odd pixel at that index plus one).
- R3: A static-plane write beat drives `mem_be` = 2'b10 and `mem_wdata` = {pixel[7:3], 3'b000, 8'h00}.
- R4: A dynamic-plane write beat drives `mem_be` = 2'b01 and `mem_wdata` = {8'h00, 5'b00000, pixel[2:0]}.
- R5: A write with exactly one byte enable set is a single beat (`mem_len` = 0). `cpu_be` = 2'b01 writes the low CPU byte to the even pixel. `cpu_be` = 2'b10 writes the high CPU byte to the odd pixel.
- R6: A write with `cpu_be` = 2'b11 is a two-beat burst (`mem_len` = 1) starting at the even pixel. The first beat carries the low CPU byte and the second beat, at the next word, carries the high CPU byte.
- R7: Every read is a two-beat burst (`mem_len` = 1, `mem_be` = 2'b11) starting at the even pixel, whatever the byte enables are.
- R8: Read data packs the even pixel into `cpu_rdata[7:0]` and the odd pixel into `cpu_rdata[15:8]`. A static read returns memory bits [15:11] in pixel bits [7:3] with bits [2:0] zero. A dynamic read returns memory bits [2:0] in pixel bits [2:0] with bits [7:3] zero.
- R9: `mem_req`, `mem_addr`, `mem_len` and `mem_we` stay stable until the last beat's `mem_ack`. `cpu_ack` is a one-cycle pulse in the cycle after that last beat.
- R10: A write with `cpu_be` = 2'b00 makes no memory request and is acknowledged in the cycle after it is accepted.
- R11: A write to one plane leaves the other plane's part of the same pixel unchanged, as seen through later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | PLANE_BIT+1 | CPU byte address; top bit selects the plane |
| cpu_be | input | 2 | CPU byte enables (bit 0 low byte, bit 1 high byte) |
| cpu_wdata | input | 16 | CPU write data, two pixels |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Packed read pixels, valid with `cpu_ack` |
| mem_req | output | 1 | Memory burst request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | PLANE_BIT | First word address of the burst |
| mem_len | output | 1 | 0 = one beat, 1 = two beats |
| mem_be | output | 2 | Lane enables (bit 1 upper/static, bit 0 lower/dynamic) |
| mem_wdata | output | 16 | Write data of the current beat |
| mem_ack | input | 1 | Beat completion strobe |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |

## Verification
The bench builds the bridge with `PLANE_BIT` = 12, which gives 4096-pixel planes. With planes this small, a full memory model and reference planes fit in the bench, and random addresses often hit the same pixels from both planes. That is what exercises the cross-plane preservation and the masking. `STATIC_BITS` is left at 5, so the lane split in the requirements is the one tested. The memory model adds random wait states between beats, so the acknowledge timing and signal stability are tested under stretched bursts.

// File: rtl/fb_plane_bridge.sv
module fb_plane_bridge #(
  parameter int PLANE_BIT   = 19,
  parameter int STATIC_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [PLANE_BIT:0]   cpu_addr,
  input  logic [1:0]           cpu_be,
  input  logic [15:0]          cpu_wdata,
  output logic                 cpu_ack,
  output logic [15:0]          cpu_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [PLANE_BIT-1:0] mem_addr,
  output logic                 mem_len,
  output logic [1:0]           mem_be,
  output logic [15:0]          mem_wdata,
  input  logic                 mem_ack,
  input  logic [15:0]          mem_rdata
);
  localparam int       DYN_BITS = 8 - STATIC_BITS;
  localparam bit [7:0] DMASK    = 8'((1 << DYN_BITS) - 1);
  localparam bit [7:0] SMASK    = ~DMASK;

  logic                 busy, beat, we_r, plane_r, two_r;
  logic [PLANE_BIT-1:0] addr_r;
  logic [7:0]           px0_r, px1_r;
  logic [7:0]           wr_px, rd_px;

  wire go      = cpu_req && !busy && !cpu_ack;
  wire odd_one = cpu_we && (cpu_be == 2'b10);

  assign wr_px     = beat ? px1_r : px0_r;
  assign rd_px     = plane_r ? (mem_rdata[7:0] & DMASK) : (mem_rdata[15:8] & SMASK);
  assign mem_req   = busy;
  assign mem_we    = we_r;
  assign mem_addr  = addr_r;
  assign mem_len   = two_r;
  assign mem_be    = !we_r ? 2'b11 : (plane_r ? 2'b01 : 2'b10);
  assign mem_wdata = plane_r ? {8'h00, wr_px & DMASK} : {wr_px & SMASK, 8'h00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      beat      <= 1'b0;
      we_r      <= 1'b0;
      plane_r   <= 1'b0;
      two_r     <= 1'b0;
      addr_r    <= '0;
      px0_r     <= '0;
      px1_r     <= '0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      if (go) begin
        if (cpu_we && cpu_be == 2'b00) begin
          cpu_ack <= 1'b1;
        end else begin
          busy    <= 1'b1;
          beat    <= 1'b0;
          we_r    <= cpu_we;
          plane_r <= cpu_addr[PLANE_BIT];
          two_r   <= !cpu_we || (cpu_be == 2'b11);
          addr_r  <= {cpu_addr[PLANE_BIT-1:1], odd_one};
          px0_r   <= odd_one ? cpu_wdata[15:8] : cpu_wdata[7:0];
          px1_r   <= cpu_wdata[15:8];
        end
      end else if (busy && mem_ack) begin
        if (!we_r) begin
          if (beat) cpu_rdata[15:8] <= rd_px;
          else      cpu_rdata[7:0]  <= rd_px;
        end
        beat <= 1'b1;
        if (beat || !two_r) begin
          busy    <= 1'b0;
          cpu_ack <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fb_plane_bridge_chk.sv
module fb_plane_bridge_chk #(
  parameter int PLANE_BIT   = 19,
  parameter int STATIC_BITS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_ack,
  input logic [15:0]          cpu_rdata,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic [PLANE_BIT-1:0] mem_addr,
  input logic                 mem_len,
  input logic [1:0]           mem_be,
  input logic [15:0]          mem_wdata,
  input logic                 mem_ack,
  input logic                 we_r,
  input logic                 plane_r
);
  localparam int       DYN_BITS = 8 - STATIC_BITS;
  localparam bit [7:0] DMASK    = 8'((1 << DYN_BITS) - 1);
  localparam bit [7:0] SMASK    = ~DMASK;

  AST_STATIC_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !plane_r |-> mem_be == 2'b10 && (mem_wdata[15:8] & DMASK) == 8'h00 && mem_wdata[7:0] == 8'h00); // R3
  AST_DYN_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && plane_r |-> mem_be == 2'b01 && (mem_wdata[7:0] & SMASK) == 8'h00 && mem_wdata[15:8] == 8'h00); // R4
  AST_WRITE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> $countones(mem_be) == 1); // R5
  AST_READ_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_be == 2'b11 && mem_len); // R7
  AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !we_r |-> ((plane_r ? SMASK : DMASK) & (cpu_rdata[7:0] | cpu_rdata[15:8])) == 8'h00); // R8
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_we)); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack); // R9
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !mem_req); // R9
endmodule

bind fb_plane_bridge fb_plane_bridge_chk #(.PLANE_BIT(PLANE_BIT), .STATIC_BITS(STATIC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
  .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .we_r(we_r), .plane_r(plane_r)
);

// File: tb/fb_plane_bridge_tb.sv
module fb_plane_bridge_tb;
  localparam int PB = 12;
  localparam int NPIX = 1 << PB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [PB:0]   cpu_addr = '0;
  logic [1:0]    cpu_be = '0;
  logic [15:0]   cpu_wdata = '0;
  logic          cpu_ack;
  logic [15:0]   cpu_rdata;
  logic          mem_req, mem_we, mem_len;
  logic [PB-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [15:0]   mem_rdata = '0;

  always #2 clk = ~clk;

  fb_plane_bridge #(.PLANE_BIT(PB), .STATIC_BITS(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int tests = 0, fails = 0;
  logic [15:0] mem [NPIX];
  logic [7:0]  refs [NPIX];
  logic [7:0]  refd [NPIX];

  int          nb;
  logic [PB-1:0] la [2];
  logic [1:0]  lbe [2];
  logic [15:0] lwd [2];
  logic        llen [2];
  logic        lwe [2];

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : memmodel
    int mb;
    logic [PB-1:0] a;
    mb = 0;
    forever begin
      @(negedge clk);
      if (mem_req && $urandom_range(0, 2) != 0) begin
        a = mem_addr + PB'(mb);
        if (mem_we) begin
          if (mem_be[1]) mem[a][15:8] = mem_wdata[15:8];
          if (mem_be[0]) mem[a][7:0]  = mem_wdata[7:0];
        end else begin
          mem_rdata = mem[a];
        end
        if (nb < 2) begin
          la[nb] = a; lbe[nb] = mem_be; lwd[nb] = mem_wdata; llen[nb] = mem_len; lwe[nb] = mem_we;
        end
        nb++;
        mb = (mb == 0 && mem_len) ? 1 : 0;
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  function automatic logic [15:0] exp_wd(input logic plane, input logic [7:0] px);
    return plane ? {8'h00, 5'b0, px[2:0]} : {px[7:3], 3'b000, 8'h00};
  endfunction

  task automatic xfer(input logic we, input logic [PB:0] a, input logic [1:0] be,
                      input logic [15:0] wd, output logic [15:0] rd);
    int cyc, ebeats;
    logic plane;
    logic [PB-1:0] base;
    logic [PB-1:0] ea [2];
    logic [7:0] ep [2];
    plane = a[PB];
    base = {a[PB-1:1], 1'b0};
    ebeats = 0;
    if (!we) begin
      ebeats = 2; ea[0] = base; ea[1] = base + 1;
    end else if (be == 2'b11) begin
      ebeats = 2; ea[0] = base; ea[1] = base + 1; ep[0] = wd[7:0]; ep[1] = wd[15:8];
    end else if (be == 2'b01) begin
      ebeats = 1; ea[0] = base; ep[0] = wd[7:0];
    end else if (be == 2'b10) begin
      ebeats = 1; ea[0] = base + 1; ep[0] = wd[15:8];
    end
    @(negedge clk);
    nb = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ack && cyc < 60);
    chk("R9 ack arrives", cpu_ack, 32'(cpu_ack), 1);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    chk("R9/R10 beats done at ack", nb == ebeats, nb, ebeats);
    for (int i = 0; i < ebeats && i < nb; i++) begin
      chk("R2 beat address", la[i] == ea[i], 32'(la[i]), 32'(ea[i]));
      chk("R5/R6/R7 burst length", llen[i] == (ebeats == 2), 32'(llen[i]), 32'(ebeats == 2));
      chk("R2 direction", lwe[i] == we, 32'(lwe[i]), 32'(we));
      if (we) begin
        chk(plane ? "R4 lane enable" : "R3 lane enable", lbe[i] == (plane ? 2'b01 : 2'b10),
            32'(lbe[i]), plane ? 32'd1 : 32'd2);
        chk(plane ? "R4 write data" : "R3 write data", lwd[i] == exp_wd(plane, ep[i]),
            32'(lwd[i]), 32'(exp_wd(plane, ep[i])));
        if (plane) refd[ea[i]] = ep[i] & 8'h07;
        else       refs[ea[i]] = ep[i] & 8'hF8;
      end else begin
        chk("R7 read lanes", lbe[i] == 2'b11, 32'(lbe[i]), 3);
      end
    end
    @(negedge clk);
    chk("R9 ack single pulse", !cpu_ack, 32'(cpu_ack), 0);
  endtask

  task automatic rd_check(input string req, input logic [PB:0] a);
    logic [15:0] rd, ex;
    logic [PB-1:0] base;
    base = {a[PB-1:1], 1'b0};
    xfer(1'b0, a, 2'($urandom_range(0, 3)), 16'h0, rd);
    ex = a[PB] ? {refd[base + 1], refd[base]} : {refs[base + 1], refs[base]};
    chk(req, rd == ex, 32'(rd), 32'(ex));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < NPIX; i++) begin
      mem[i] = 16'($urandom);
      refs[i] = mem[i][15:8] & 8'hF8;
      refd[i] = mem[i][7:0] & 8'h07;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset ack", !cpu_ack, 32'(cpu_ack), 0);
    chk("R1 reset req", !mem_req, 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", !cpu_ack && !mem_req, {cpu_ack, mem_req}, 0);

    xfer(1'b1, 13'h0000, 2'b01, 16'h12FF, d);
    rd_check("R8 static read after low write", 13'h0000);
    xfer(1'b1, 13'h1011, 2'b10, 16'hFF34, d);
    rd_check("R8 dynamic read after high write", 13'h1010);
    xfer(1'b1, 13'h0020, 2'b11, 16'hABCD, d);
    rd_check("R6 static burst readback", 13'h0021);
    xfer(1'b1, 13'h1FFE, 2'b11, 16'hFFFF, d);
    rd_check("R6 dynamic burst at top", 13'h1FFE);
    xfer(1'b1, 13'h0040, 2'b00, 16'hFFFF, d);
    rd_check("R10 no-enable write leaves pixels", 13'h0040);
    xfer(1'b1, 13'h0060, 2'b11, 16'hFFFF, d);
    xfer(1'b1, 13'h1060, 2'b11, 16'h0000, d);
    rd_check("R11 static kept after dynamic write", 13'h0060);
    rd_check("R11 dynamic written", 13'h1060);
    xfer(1'b1, 13'h0060, 2'b01, 16'h0000, d);
    rd_check("R11 dynamic kept after static write", 13'h1060);

    for (int n = 0; n < 400; n++) begin
      logic [PB:0] a;
      a = {1'($urandom), 4'($urandom), (PB-4)'($urandom_range(0, 15))};
      if ($urandom_range(0, 1) == 0) begin
        logic [1:0] be;
        be = ($urandom_range(0, 15) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
        xfer(1'b1, a, be, 16'($urandom), d);
      end else begin
        rd_check("R8/R11 random read", a);
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule